// File: doc/BRIEF.md
# Interrupt Source State Controller

This block is a bank of interrupt sources that sit in front of an interrupt presentation unit. Each source is given a kind once, either level or message. It holds a destination server number, an eight-bit priority and a few status flags. Activity on a source's input line turns into a presentation request. A request carries the server, a global source number and the priority. The presentation unit may then turn an offer down, and it signals end of interrupt once it has finished with a source. Either notice reaches the bank as a global number, and the bank maps that number back to a local source.

Level sources track their input with an asserted flag and a sent flag. Message sources track a refused delivery with a rejected flag, and an event that came in while masked with a masked-pending flag. When the presentation side asks for a resend, a scan walks the sources one per clock from index 0. A refused message is offered again during that scan, and each level source evaluates its request rule again. When requests from several sources arise together, they leave the bank one per cycle with the lowest index first.

Top module: `irq_src_bank`

## Requirements
- R1: While rst_n is low, every source's kind becomes unset (code 00) and no request or scan is active. A one-cycle `state_clr_i` makes the following changes: every priority becomes 0xFF, every status flag and server is cleared, and every queued request is dropped. Kinds are kept. No request appears in the cycle after the clear.
- R2: Kind codes are 00 unset, 01 message and 10 level. A kind write takes effect only on an unset source, and later writes are ignored. An unset source never requests, whatever its line or configuration.
- R3: Priority 0xFF means masked, and a masked source never requests. A message source requests once for each cycle its line is high while unmasked. A message event while masked sets masked-pending. The next configuration write that leaves the source unmasked clears that flag and issues exactly one request.
- R4: A level source requests only when it is unmasked, its asserted flag is set and its sent flag is clear. Issuing the request sets sent, so a held line gives a single request.
- R5: A reject makes a message source set its rejected flag and makes a level source clear its sent flag. Neither requests again on the reject itself. Only a resend scan replays a rejected message, and it does so once.
- R6: An end of interrupt clears a level source's sent flag. It does not itself re-request. A message source ignores it, so its rejected flag survives.
- R7: A configuration write to a level source re-evaluates the level rule.
- R8: The global number is 0x1000 plus the local index. Reject and end-of-interrupt numbers are mapped back by subtracting 0x1000. Numbers outside the bank are ignored.
- R9: `resend_i` starts a scan that visits index j at the (j+1)-th edge after the start edge. `scan_busy_o` stays high for NSRC cycles, and `resend_i` is ignored while the scan is busy.
- R10: When several requests are queued, the lowest index is issued first. The others are held and issued one per cycle.
- R11: A request stimulus sampled at edge k shows on `req_valid_o` after edge k+1 for one cycle. It carries the source's current server and priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| state_clr_i | input | 1 | Synchronous clear of source state, kinds kept |
| kind_wr_i | input | 1 | Kind write strobe |
| kind_idx_i | input | IDX_W | Source addressed by the kind write |
| kind_val_i | input | 2 | Kind code: 01 message, 10 level |
| line_i | input | NSRC | Per-source input lines |
| cfg_wr_i | input | 1 | Server and priority write strobe |
| cfg_idx_i | input | IDX_W | Source addressed by the configuration write |
| cfg_srv_i | input | SRV_W | New server number |
| cfg_prio_i | input | PRIO_W | New priority, all ones masks |
| rej_i | input | 1 | Reject notice strobe |
| rej_num_i | input | NUM_W | Global number being rejected |
| eoi_i | input | 1 | End-of-interrupt strobe |
| eoi_num_i | input | NUM_W | Global number being completed |
| resend_i | input | 1 | Start a resend scan |
| req_valid_o | output | 1 | Presentation request valid, one cycle |
| req_srv_o | output | SRV_W | Destination server of the request |
| req_num_o | output | NUM_W | Global source number of the request |
| req_prio_o | output | PRIO_W | Priority of the request |
| scan_busy_o | output | 1 | Resend scan in progress |

## Verification
A stimulus is sampled at rising edge k, and the source state and queued request update at that same edge. The output register loads at edge k+1, so the bench drives on falling edges and reads one falling edge after edge k+1. A resend started at edge k reaches index j at edge k+1+j, and its replayed request is due after edge k+2+j. The bench therefore counts falling-edge samples from the start edge and checks the exact sample index at which a replay appears, together with the length of the busy window. Queued requests are read on consecutive samples to confirm their order and that exactly one leaves per cycle.

// File: rtl/irq_src_pkg.sv
package irq_src_pkg;

  typedef enum logic [1:0] {
    KIND_NONE = 2'b00,
    KIND_MSG  = 2'b01,
    KIND_LVL  = 2'b10
  } src_kind_e;

  typedef struct packed {
    logic asserted;
    logic sent;
    logic rejected;
    logic mpend;
  } src_stat_t;

endpackage

// File: rtl/irq_src_slot.sv
module irq_src_slot
  import irq_src_pkg::*;
#(
  parameter int SRV_W  = 4,
  parameter int PRIO_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              kind_wr_i,
  input  logic [1:0]        kind_i,
  input  logic              line_i,
  input  logic              cfg_wr_i,
  input  logic [SRV_W-1:0]  cfg_srv_i,
  input  logic [PRIO_W-1:0] cfg_prio_i,
  input  logic              rej_i,
  input  logic              eoi_i,
  input  logic              scan_i,
  input  logic              grant_i,
  output logic              pend_o,
  output logic [SRV_W-1:0]  srv_o,
  output logic [PRIO_W-1:0] prio_o
);

  localparam logic [PRIO_W-1:0] MASK = '1;

  src_kind_e         kind_q, kind_n;
  src_stat_t         stat_q, stat_n;
  logic [SRV_W-1:0]  srv_q, srv_n;
  logic [PRIO_W-1:0] prio_q, prio_n;
  logic              pend_q, pend_n;
  logic              req, lvl_eval;
  logic              fld_en, kind_en;

  assign fld_en  = cfg_wr_i | clr_i;
  assign kind_en = kind_wr_i & (kind_q == KIND_NONE) & ~clr_i;

  always_comb begin
    kind_n   = kind_q;
    stat_n   = stat_q;
    srv_n    = srv_q;
    prio_n   = prio_q;
    req      = 1'b0;
    lvl_eval = 1'b0;
    if (clr_i) begin
      srv_n  = '0;
      prio_n = MASK;
      stat_n = '0;
    end else begin
      if (kind_en) kind_n = src_kind_e'(kind_i);
      if (cfg_wr_i) begin
        srv_n  = cfg_srv_i;
        prio_n = cfg_prio_i;
      end
      case (kind_n)
        KIND_MSG: begin
          if (rej_i) stat_n.rejected = 1'b1;
          if (line_i) begin
            if (prio_n == MASK) stat_n.mpend = 1'b1;
            else                req = 1'b1;
          end
          if (cfg_wr_i && stat_n.mpend && (prio_n != MASK)) begin
            stat_n.mpend = 1'b0;
            req          = 1'b1;
          end
          if (scan_i && stat_n.rejected) begin
            stat_n.rejected = 1'b0;
            if (prio_n != MASK) req = 1'b1;
          end
        end
        KIND_LVL: begin
          if (rej_i || eoi_i) stat_n.sent = 1'b0;
          if (line_i != stat_n.asserted) begin
            stat_n.asserted = line_i;
            lvl_eval        = 1'b1;
          end
          if (cfg_wr_i || scan_i) lvl_eval = 1'b1;
          if (lvl_eval && (prio_n != MASK) && stat_n.asserted && !stat_n.sent) begin
            stat_n.sent = 1'b1;
            req         = 1'b1;
          end
        end
        default: ;
      endcase
    end
    if (clr_i) pend_n = 1'b0;
    else       pend_n = ((pend_q & ~grant_i) | req) & (prio_n != MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= KIND_NONE;
    end else if (kind_en) begin
      kind_q <= kind_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srv_q  <= '0;
      prio_q <= MASK;
    end else if (fld_en) begin
      srv_q  <= srv_n;
      prio_q <= prio_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      pend_q <= 1'b0;
    end else begin
      stat_q <= stat_n;
      pend_q <= pend_n;
    end
  end

  assign pend_o = pend_q;
  assign srv_o  = srv_q;
  assign prio_o = prio_q;

endmodule

// File: rtl/irq_req_arb.sv
module irq_req_arb #(
  parameter int N     = 16,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     pend_i,
  output logic [N-1:0]     grant_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);

  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i]) idx_o = IDX_W'(i);
    end
    any_o   = |pend_i;
    grant_o = any_o ? (N'(1) << idx_o) : '0;
  end

endmodule

// File: rtl/irq_resend_scan.sv
module irq_resend_scan #(
  parameter int N     = 16,
  parameter int IDX_W = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         start_i,
  output logic         busy_o,
  output logic [N-1:0] hit_o
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  logic             busy_q, busy_n;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic             step_en;

  assign step_en = busy_q | start_i | clr_i;

  always_comb begin
    busy_n = busy_q;
    idx_n  = idx_q;
    if (clr_i) begin
      busy_n = 1'b0;
      idx_n  = '0;
    end else if (!busy_q) begin
      busy_n = start_i;
      idx_n  = '0;
    end else if (idx_q == LAST) begin
      busy_n = 1'b0;
      idx_n  = '0;
    end else begin
      idx_n = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (step_en) begin
      busy_q <= busy_n;
      idx_q  <= idx_n;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_hit
    assign hit_o[i] = busy_q & (idx_q == IDX_W'(i));
  end

  assign busy_o = busy_q;

endmodule

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
  parameter int                NSRC     = 16,
  parameter int                SRV_W    = 4,
  parameter int                PRIO_W   = 8,
  parameter int                NUM_W    = 16,
  parameter logic [NUM_W-1:0]  NUM_BASE = 16'h1000,
  localparam int               IDX_W    = $clog2(NSRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              state_clr_i,
  input  logic              kind_wr_i,
  input  logic [IDX_W-1:0]  kind_idx_i,
  input  logic [1:0]        kind_val_i,
  input  logic [NSRC-1:0]   line_i,
  input  logic              cfg_wr_i,
  input  logic [IDX_W-1:0]  cfg_idx_i,
  input  logic [SRV_W-1:0]  cfg_srv_i,
  input  logic [PRIO_W-1:0] cfg_prio_i,
  input  logic              rej_i,
  input  logic [NUM_W-1:0]  rej_num_i,
  input  logic              eoi_i,
  input  logic [NUM_W-1:0]  eoi_num_i,
  input  logic              resend_i,
  output logic              req_valid_o,
  output logic [SRV_W-1:0]  req_srv_o,
  output logic [NUM_W-1:0]  req_num_o,
  output logic [PRIO_W-1:0] req_prio_o,
  output logic              scan_busy_o
);

  localparam logic [NUM_W-1:0] SPAN = NUM_W'(NSRC);

  logic [NUM_W-1:0]  rej_off, eoi_off;
  logic              rej_ok, eoi_ok;
  logic [NSRC-1:0]   pend, grant, scan_hit;
  logic [IDX_W-1:0]  gidx;
  logic              gany;
  logic [SRV_W-1:0]  srv_a  [NSRC];
  logic [PRIO_W-1:0] prio_a [NSRC];

  logic              vld_q, vld_n;
  logic [SRV_W-1:0]  osrv_q, osrv_n;
  logic [NUM_W-1:0]  onum_q, onum_n;
  logic [PRIO_W-1:0] oprio_q, oprio_n;
  logic              out_en;

  // Map global notice numbers back to local indices.
  assign rej_off = rej_num_i - NUM_BASE;
  assign eoi_off = eoi_num_i - NUM_BASE;
  assign rej_ok  = rej_i & (rej_off < SPAN);
  assign eoi_ok  = eoi_i & (eoi_off < SPAN);

  irq_resend_scan #(.N(NSRC), .IDX_W(IDX_W)) u_scan (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (state_clr_i),
    .start_i (resend_i),
    .busy_o  (scan_busy_o),
    .hit_o   (scan_hit)
  );

  for (genvar i = 0; i < NSRC; i++) begin : g_slot
    irq_src_slot #(.SRV_W(SRV_W), .PRIO_W(PRIO_W)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_i      (state_clr_i),
      .kind_wr_i  (kind_wr_i & (kind_idx_i == IDX_W'(i))),
      .kind_i     (kind_val_i),
      .line_i     (line_i[i]),
      .cfg_wr_i   (cfg_wr_i & (cfg_idx_i == IDX_W'(i))),
      .cfg_srv_i  (cfg_srv_i),
      .cfg_prio_i (cfg_prio_i),
      .rej_i      (rej_ok & (rej_off[IDX_W-1:0] == IDX_W'(i))),
      .eoi_i      (eoi_ok & (eoi_off[IDX_W-1:0] == IDX_W'(i))),
      .scan_i     (scan_hit[i]),
      .grant_i    (grant[i]),
      .pend_o     (pend[i]),
      .srv_o      (srv_a[i]),
      .prio_o     (prio_a[i])
    );
  end

  irq_req_arb #(.N(NSRC), .IDX_W(IDX_W)) u_arb (
    .pend_i  (pend),
    .grant_o (grant),
    .idx_o   (gidx),
    .any_o   (gany)
  );

  assign out_en = gany & ~state_clr_i;

  always_comb begin
    vld_n   = out_en;
    osrv_n  = srv_a[gidx];
    onum_n  = NUM_BASE + NUM_W'(gidx);
    oprio_n = prio_a[gidx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osrv_q  <= '0;
      onum_q  <= '0;
      oprio_q <= '1;
    end else if (out_en) begin
      osrv_q  <= osrv_n;
      onum_q  <= onum_n;
      oprio_q <= oprio_n;
    end
  end

  assign req_valid_o = vld_q;
  assign req_srv_o   = osrv_q;
  assign req_num_o   = onum_q;
  assign req_prio_o  = oprio_q;

endmodule

// File: rtl/irq_src_bank_chk.sv
module irq_src_bank_chk #(
  parameter int               NSRC     = 16,
  parameter int               PRIO_W   = 8,
  parameter int               NUM_W    = 16,
  parameter logic [NUM_W-1:0] NUM_BASE = 16'h1000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              state_clr_i,
  input logic              resend_i,
  input logic              scan_busy_o,
  input logic              req_valid_o,
  input logic [NUM_W-1:0]  req_num_o,
  input logic [PRIO_W-1:0] req_prio_o,
  input logic [NSRC-1:0]   grant
);

  localparam logic [NUM_W-1:0]  NUM_END = NUM_BASE + NUM_W'(NSRC);
  localparam logic [PRIO_W-1:0] MASK    = '1;

  AST_CLR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    state_clr_i |=> !req_valid_o); // R1

  AST_NO_MASKED_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o |-> (req_prio_o != MASK)); // R3

  AST_NUM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o |-> ((req_num_o >= NUM_BASE) && (req_num_o < NUM_END))); // R8

  AST_SCAN_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scan_busy_o) |-> $past(resend_i)); // R9

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R10

endmodule

bind irq_src_bank irq_src_bank_chk #(
  .NSRC(NSRC), .PRIO_W(PRIO_W), .NUM_W(NUM_W), .NUM_BASE(NUM_BASE)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .state_clr_i (state_clr_i),
  .resend_i    (resend_i),
  .scan_busy_o (scan_busy_o),
  .req_valid_o (req_valid_o),
  .req_num_o   (req_num_o),
  .req_prio_o  (req_prio_o),
  .grant       (grant)
);

// File: tb/irq_src_bank_test.sv
module irq_src_bank_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        state_clr_i, kind_wr_i, cfg_wr_i, rej_i, eoi_i, resend_i;
  logic [3:0]  kind_idx_i, cfg_idx_i, cfg_srv_i;
  logic [1:0]  kind_val_i;
  logic [15:0] line_i, rej_num_i, eoi_num_i;
  logic [7:0]  cfg_prio_i;
  logic        req_valid_o, scan_busy_o;
  logic [3:0]  req_srv_o;
  logic [15:0] req_num_o;
  logic [7:0]  req_prio_o;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  always #10 clk = ~clk; // 50 MHz

  irq_src_bank uut (
    .clk(clk), .rst_n(rst_n), .state_clr_i(state_clr_i),
    .kind_wr_i(kind_wr_i), .kind_idx_i(kind_idx_i), .kind_val_i(kind_val_i),
    .line_i(line_i), .cfg_wr_i(cfg_wr_i), .cfg_idx_i(cfg_idx_i),
    .cfg_srv_i(cfg_srv_i), .cfg_prio_i(cfg_prio_i), .rej_i(rej_i),
    .rej_num_i(rej_num_i), .eoi_i(eoi_i), .eoi_num_i(eoi_num_i),
    .resend_i(resend_i), .req_valid_o(req_valid_o), .req_srv_o(req_srv_o),
    .req_num_o(req_num_o), .req_prio_o(req_prio_o), .scan_busy_o(scan_busy_o)
  );

  typedef struct packed {
    logic [15:0] ln;
    logic        cw;
    logic [3:0]  ci;
    logic [7:0]  cp;
    logic        rj;
    logic [15:0] rn;
    logic        eo;
    logic [15:0] en;
    logic        ev;
    logic [15:0] xn;
    logic [7:0]  xp;
    logic [3:0]  rq;
  } vec_t;

  // Sources 0..7 are message, 8..14 level, 15 unset.
  localparam vec_t VT [0:13] = '{
    '{16'h0004,1'b0,4'd0,8'h00,1'b0,16'h0000,1'b0,16'h0000,1'b0,16'h0000,8'h00,4'd3},  // R3 masked msg fire
    '{16'h0000,1'b1,4'd2,8'h05,1'b0,16'h0000,1'b0,16'h0000,1'b1,16'h1002,8'h05,4'd3},  // R3 unmask releases
    '{16'h0000,1'b1,4'd2,8'h05,1'b0,16'h0000,1'b0,16'h0000,1'b0,16'h0000,8'h00,4'd3},  // R3 only once
    '{16'h0004,1'b0,4'd0,8'h00,1'b0,16'h0000,1'b0,16'h0000,1'b1,16'h1002,8'h05,4'd3},  // R3 unmasked fire
    '{16'h0000,1'b1,4'd9,8'h03,1'b0,16'h0000,1'b0,16'h0000,1'b0,16'h0000,8'h00,4'd7},  // R7 not asserted
    '{16'h0200,1'b0,4'd0,8'h00,1'b0,16'h0000,1'b0,16'h0000,1'b1,16'h1009,8'h03,4'd4},  // R4 level rises
    '{16'h0200,1'b0,4'd0,8'h00,1'b0,16'h0000,1'b0,16'h0000,1'b0,16'h0000,8'h00,4'd4},  // R4 held, sent
    '{16'h0200,1'b0,4'd0,8'h00,1'b0,16'h0000,1'b1,16'h1009,1'b0,16'h0000,8'h00,4'd6},  // R6 eoi no request
    '{16'h0200,1'b1,4'd9,8'h03,1'b0,16'h0000,1'b0,16'h0000,1'b1,16'h1009,8'h03,4'd7},  // R7 cfg re-evaluates
    '{16'h0200,1'b0,4'd0,8'h00,1'b1,16'h1002,1'b0,16'h0000,1'b0,16'h0000,8'h00,4'd5},  // R5 msg reject
    '{16'h0200,1'b0,4'd0,8'h00,1'b0,16'h0000,1'b1,16'h1002,1'b0,16'h0000,8'h00,4'd6},  // R6 msg ignores eoi
    '{16'h0200,1'b0,4'd0,8'h00,1'b1,16'h1009,1'b0,16'h0000,1'b0,16'h0000,8'h00,4'd5},  // R5 level reject
    '{16'h0000,1'b0,4'd0,8'h00,1'b0,16'h0000,1'b0,16'h0000,1'b0,16'h0000,8'h00,4'd4},  // R4 level drops
    '{16'h0020,1'b0,4'd0,8'h00,1'b0,16'h0000,1'b0,16'h0000,1'b0,16'h0000,8'h00,4'd3}   // R3 masked src5
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    cyc++;
  endtask

  task automatic expect_req(input bit ev, input logic [15:0] xn,
                            input logic [7:0] xp, input string tag);
    chk(req_valid_o == ev, {tag, " valid"}, 32'(req_valid_o), 32'(ev));
    if (ev && req_valid_o) begin
      chk(req_num_o == xn, {tag, " num"}, 32'(req_num_o), 32'(xn));
      chk(req_prio_o == xp, {tag, " prio"}, 32'(req_prio_o), 32'(xp));
      chk(req_srv_o == ~xn[3:0], {tag, " server"}, 32'(req_srv_o), 32'(~xn[3:0]));
    end
  endtask

  task automatic cfg_chk(input logic [3:0] idx, input logic [7:0] pr, input bit ev,
                         input logic [15:0] xn, input string tag);
    cfg_wr_i = 1'b1; cfg_idx_i = idx; cfg_srv_i = ~idx; cfg_prio_i = pr;
    tick();
    cfg_wr_i = 1'b0;
    tick();
    expect_req(ev, xn, pr, tag);
  endtask

  task automatic pulse_chk(input logic [15:0] m, input bit ev, input logic [15:0] xn,
                           input logic [7:0] xp, input string tag);
    line_i = m;
    tick();
    line_i = '0;
    tick();
    expect_req(ev, xn, xp, tag);
  endtask

  task automatic run_scan(output int busy_cnt, output int vcnt, output int vat,
                          output logic [15:0] vnum);
    busy_cnt = 0; vcnt = 0; vat = -1; vnum = '0;
    resend_i = 1'b1;
    for (int n = 0; n < 20; n++) begin
      tick();
      if (scan_busy_o) busy_cnt++;
      if (req_valid_o) begin
        vcnt++;
        vat  = n;
        vnum = req_num_o;
      end
      if (n == 1) resend_i = 1'b0;
    end
  endtask

  initial begin
    while (cyc < 100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int bc, vc, va;
    logic [15:0] vn;
    rst_n = 1'b0; state_clr_i = 0; kind_wr_i = 0; cfg_wr_i = 0; rej_i = 0;
    eoi_i = 0; resend_i = 0; kind_idx_i = 0; cfg_idx_i = 0; cfg_srv_i = 0;
    kind_val_i = 0; line_i = 0; rej_num_i = 0; eoi_num_i = 0; cfg_prio_i = 0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk(req_valid_o == 1'b0, "R1 reset valid", 32'(req_valid_o), 0);
    chk(scan_busy_o == 1'b0, "R1 reset busy", 32'(scan_busy_o), 0);

    for (int i = 0; i < 15; i++) begin
      kind_wr_i = 1'b1; kind_idx_i = 4'(i); kind_val_i = (i < 8) ? 2'b01 : 2'b10;
      tick();
    end
    kind_wr_i = 1'b0;

    foreach (VT[i]) begin
      line_i = VT[i].ln; cfg_wr_i = VT[i].cw; cfg_idx_i = VT[i].ci;
      cfg_srv_i = ~VT[i].ci; cfg_prio_i = VT[i].cp; rej_i = VT[i].rj;
      rej_num_i = VT[i].rn; eoi_i = VT[i].eo; eoi_num_i = VT[i].en;
      tick();
      line_i = VT[i].ln & 16'hFF00; cfg_wr_i = 0; rej_i = 0; eoi_i = 0;
      tick();
      expect_req(VT[i].ev, VT[i].xn, VT[i].xp, $sformatf("R11 vec%0d R%0d", i, VT[i].rq));
    end

    // R5 R6 R9: replay of rejected src2 (eoi did not clear it) at sample 4
    run_scan(bc, vc, va, vn);
    chk(bc == 16, "R9 busy length", 32'(bc), 16);
    chk(vc == 1, "R5 replay count", 32'(vc), 1);
    chk(va == 4, "R9 replay timing", 32'(va), 4);
    chk(vn == 16'h1002, "R6 replay number", 32'(vn), 32'h1002);
    run_scan(bc, vc, va, vn);
    chk(vc == 0, "R5 replay only once", 32'(vc), 0);

    // R10 lowest index first, one per cycle
    cfg_chk(4'd1, 8'h04, 1'b0, 16'h0, "R10 cfg1");
    cfg_chk(4'd3, 8'h06, 1'b0, 16'h0, "R10 cfg3");
    line_i = 16'h000A;
    tick();
    line_i = '0;
    tick();
    expect_req(1'b1, 16'h1001, 8'h04, "R10 first");
    tick();
    expect_req(1'b1, 16'h1003, 8'h06, "R10 second");
    tick();
    expect_req(1'b0, 16'h0, 8'h00, "R10 drained");

    // R8 out-of-range reject must not mark src1
    rej_i = 1'b1; rej_num_i = 16'h2001;
    tick();
    rej_i = 1'b0;
    run_scan(bc, vc, va, vn);
    chk(vc == 0, "R8 foreign reject ignored", 32'(vc), 0);

    // R3 masked-pending src5 released by unmasking write
    cfg_chk(4'd5, 8'h07, 1'b1, 16'h1005, "R3 mpend release");

    // R2 kind set once: src2 stays message, so two pulses give two requests
    kind_wr_i = 1'b1; kind_idx_i = 4'd2; kind_val_i = 2'b10;
    tick();
    kind_wr_i = 1'b0;
    pulse_chk(16'h0004, 1'b1, 16'h1002, 8'h05, "R2 kind kept a");
    pulse_chk(16'h0004, 1'b1, 16'h1002, 8'h05, "R2 kind kept b");
    // R2 unset source 15 never requests
    cfg_chk(4'd15, 8'h01, 1'b0, 16'h0, "R2 unset cfg");
    pulse_chk(16'h8000, 1'b0, 16'h0, 8'h00, "R2 unset line");

    // R1 clear beats a request arising in the same cycle
    line_i = 16'h0002; state_clr_i = 1'b1;
    tick();
    line_i = '0; state_clr_i = 1'b0;
    tick();
    expect_req(1'b0, 16'h0, 8'h00, "R1 clear quiet");
    pulse_chk(16'h0004, 1'b0, 16'h0, 8'h00, "R1 cleared masks");
    cfg_chk(4'd2, 8'h05, 1'b1, 16'h1002, "R1 kind kept");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule